// File: doc/BRIEF.md
# Circular CORDIC Quadrant Pre-Rotation Stage

This stage sits directly ahead of a circular-mode CORDIC iteration array. The circular iterations only converge for a total angle of roughly 1.743 rad. This stage widens the usable input range so that any angle up to ±π, and any vector in any quadrant, can be processed.

To do this, it applies one exact quarter turn (+90° or −90°) by swapping the coordinates and negating one of them. It then corrects the angle word by ±π/2. A sample that is already inside the convergent region passes through unchanged. Samples tagged as linear or hyperbolic always pass through untouched, because they are not bound by the circular limit. The iteration stages and the gain correction are not part of this block.

Samples enter and leave on a valid/ready stream, and the stage holds exactly one register of latency.
- A sample is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the output fields hold and `in_ready` is low.
- The mode and coordinate sideband fields travel with their sample.

Top module: `qrot_prerotate`

## Requirements
- R1: An accepted sample appears on the output, with `out_valid` high, on the rising edge that follows acceptance.
- R2: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output field holds its value.
- R3: When `in_coord` is not 2'b01 (2'b00 linear, 2'b10 hyperbolic, 2'b11 unused), x, y and z pass through unchanged in both modes.
- R4: This applies to circular rotation (`in_coord` = 2'b01, `in_vec` = 0). The angle z is signed fixed point with 15 fraction bits, so π/2 is 51472. When z > 51472, the output is (−y, x, z − 51472).
- R5: In circular rotation with z < −51472, the output is (y, −x, z + 51472).
- R6: In circular rotation with −51472 ≤ z ≤ 51472 (both bounds included), the sample passes through unchanged.
- R7: In circular vectoring (`in_vec` = 1) with x < 0 and y ≥ 0, the output is (y, −x, z + 51472). With the usual starting z of 0, this gives z = +π/2.
- R8: In circular vectoring with x < 0 and y < 0, the output is (−y, x, z − 51472).
- R9: In circular vectoring with x ≥ 0, the sample passes through unchanged.
- R10: Negating the most negative coordinate value −32768 produces +32767 instead of wrapping.
- R11: `out_vec` and `out_coord` equal the `in_vec` and `in_coord` of the same sample.
- R12: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Stage can take a sample this cycle |
| in_x | input | 16 | Signed x coordinate |
| in_y | input | 16 | Signed y coordinate |
| in_z | input | 18 | Signed angle, 15 fraction bits |
| in_vec | input | 1 | 0 rotation, 1 vectoring |
| in_coord | input | 2 | Coordinate system, 2'b01 circular |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream accepts the output |
| out_x | output | 16 | Adjusted x |
| out_y | output | 16 | Adjusted y |
| out_z | output | 18 | Adjusted angle |
| out_vec | output | 1 | Mode of the output sample |
| out_coord | output | 2 | Coordinate system of the output sample |

## Verification
The hardest situations to reach are the exact comparison bounds and the saturating negate.

For the bounds, the stimulus places z precisely at ±51472 and one code beyond.

For saturation, −32768 must land on the coordinate that gets negated, and in the same sample the branch conditions must route it there. A rotation sample with y = −32768 and z above π/2 does this, as does a vectoring sample with x = −32768.

Back-pressure is forced by holding `out_ready` low across several cycles while a sample is parked. A randomized stretch with irregular `out_ready` mixes every branch with stalls.

// File: rtl/qrot_pkg.sv
package qrot_pkg;

  typedef enum logic [1:0] {
    CS_LINEAR     = 2'b00,
    CS_CIRCULAR   = 2'b01,
    CS_HYPERBOLIC = 2'b10,
    CS_SPARE      = 2'b11
  } coord_e;

  typedef enum logic [1:0] {
    TURN_NONE = 2'b00,
    TURN_CCW  = 2'b01,
    TURN_CW   = 2'b10
  } turn_e;

  // Quarter turn (pi/2) in an angle format with frac fraction bits, rounded.
  function automatic int quarter_turn(input int frac);
    return $rtoi(1.5707963267948966 * (2.0 ** frac) + 0.5);
  endfunction

endpackage

// File: rtl/qrot_negsat.sv
module qrot_negsat #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] neg
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (a == MOST_NEG) neg = MOST_POS;
    else               neg = W'(-$signed(a));
  end
endmodule

// File: rtl/qrot_decide.sv
module qrot_decide
  import qrot_pkg::*;
#(
  parameter int XY_W   = 16,
  parameter int Z_W    = 18,
  parameter int Z_FRAC = 15
) (
  input  logic [XY_W-1:0] x,
  input  logic [XY_W-1:0] y,
  input  logic [Z_W-1:0]  z,
  input  logic            vec,
  input  logic [1:0]      coord,
  output turn_e           turn
);
  localparam logic signed [Z_W-1:0] QT = Z_W'(quarter_turn(Z_FRAC));

  always_comb begin
    turn = TURN_NONE;
    if (coord_e'(coord) == CS_CIRCULAR) begin
      if (!vec) begin
        if ($signed(z) > QT)       turn = TURN_CCW;
        else if ($signed(z) < -QT) turn = TURN_CW;
      end else if (x[XY_W-1]) begin
        turn = y[XY_W-1] ? TURN_CCW : TURN_CW;
      end
    end
  end
endmodule

// File: rtl/qrot_turn.sv
module qrot_turn
  import qrot_pkg::*;
#(
  parameter int XY_W   = 16,
  parameter int Z_W    = 18,
  parameter int Z_FRAC = 15
) (
  input  turn_e           turn,
  input  logic [XY_W-1:0] x,
  input  logic [XY_W-1:0] y,
  input  logic [Z_W-1:0]  z,
  output logic [XY_W-1:0] x_o,
  output logic [XY_W-1:0] y_o,
  output logic [Z_W-1:0]  z_o
);
  localparam logic [Z_W-1:0] QT = Z_W'(quarter_turn(Z_FRAC));

  logic [XY_W-1:0] x_neg, y_neg;

  qrot_negsat #(.W(XY_W)) u_neg_x (.a(x), .neg(x_neg));
  qrot_negsat #(.W(XY_W)) u_neg_y (.a(y), .neg(y_neg));

  always_comb begin
    unique case (turn)
      TURN_CCW: begin   // +90: (-y, x), angle minus pi/2
        x_o = y_neg;
        y_o = x;
        z_o = z - QT;
      end
      TURN_CW: begin    // -90: (y, -x), angle plus pi/2
        x_o = y;
        y_o = x_neg;
        z_o = z + QT;
      end
      default: begin
        x_o = x;
        y_o = y;
        z_o = z;
      end
    endcase
  end
endmodule

// File: rtl/qrot_prerotate.sv
module qrot_prerotate
  import qrot_pkg::*;
#(
  parameter int XY_W   = 16,
  parameter int Z_W    = 18,
  parameter int Z_FRAC = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XY_W-1:0] in_x,
  input  logic [XY_W-1:0] in_y,
  input  logic [Z_W-1:0]  in_z,
  input  logic            in_vec,
  input  logic [1:0]      in_coord,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XY_W-1:0] out_x,
  output logic [XY_W-1:0] out_y,
  output logic [Z_W-1:0]  out_z,
  output logic            out_vec,
  output logic [1:0]      out_coord
);
  turn_e           turn;
  logic [XY_W-1:0] nx, ny;
  logic [Z_W-1:0]  nz;
  logic            take;

  qrot_decide #(.XY_W(XY_W), .Z_W(Z_W), .Z_FRAC(Z_FRAC)) u_decide (
    .x(in_x), .y(in_y), .z(in_z), .vec(in_vec), .coord(in_coord), .turn(turn)
  );

  qrot_turn #(.XY_W(XY_W), .Z_W(Z_W), .Z_FRAC(Z_FRAC)) u_turn (
    .turn(turn), .x(in_x), .y(in_y), .z(in_z), .x_o(nx), .y_o(ny), .z_o(nz)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_x     <= '0;
      out_y     <= '0;
      out_z     <= '0;
      out_vec   <= 1'b0;
      out_coord <= 2'b00;
    end else if (take) begin
      out_x     <= nx;
      out_y     <= ny;
      out_z     <= nz;
      out_vec   <= in_vec;
      out_coord <= in_coord;
    end
  end
endmodule

// File: rtl/qrot_prerotate_chk.sv
module qrot_prerotate_chk
  import qrot_pkg::*;
#(
  parameter int XY_W   = 16,
  parameter int Z_W    = 18,
  parameter int Z_FRAC = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [XY_W-1:0] in_x,
  input logic [XY_W-1:0] in_y,
  input logic [Z_W-1:0]  in_z,
  input logic            in_vec,
  input logic [1:0]      in_coord,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XY_W-1:0] out_x,
  input logic [XY_W-1:0] out_y,
  input logic [Z_W-1:0]  out_z,
  input logic            out_vec,
  input logic [1:0]      out_coord
);
  localparam logic signed [Z_W-1:0] QT   = Z_W'(quarter_turn(Z_FRAC));
  localparam logic signed [Z_W-1:0] HALF = Z_W'(2 * quarter_turn(Z_FRAC));

  logic acc, circ_in;
  assign acc     = in_valid && in_ready;
  assign circ_in = (in_coord == 2'b01);

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_stall_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)
                                   && $stable(out_z) && $stable(out_coord)));

  p_pass_noncirc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !circ_in) |=> (out_x == $past(in_x) && out_y == $past(in_y)
                           && out_z == $past(in_z)));

  p_angle_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && circ_in && !in_vec && $signed(in_z) <= HALF && $signed(in_z) >= -HALF)
      |=> ($signed(out_z) <= QT && $signed(out_z) >= -QT));

  p_right_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && circ_in && in_vec) |=> !out_x[XY_W-1]);

  p_sideband_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_vec == $past(in_vec) && out_coord == $past(in_coord)));
endmodule

bind qrot_prerotate qrot_prerotate_chk #(.XY_W(XY_W), .Z_W(Z_W), .Z_FRAC(Z_FRAC)) u_chk (.*);

// File: tb/qrot_prerotate_test.sv
module qrot_prerotate_test;
  localparam int XY_W = 16;
  localparam int Z_W  = 18;
  localparam int QT   = 51472;
  localparam int EW   = 2*XY_W + Z_W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready;
  logic [XY_W-1:0] in_x = '0, in_y = '0, out_x, out_y;
  logic [Z_W-1:0]  in_z = '0, out_z;
  logic in_vec = 1'b0, out_vec;
  logic [1:0] in_coord = 2'b00, out_coord;

  int compared = 0, mismatched = 0, rdy_mode = 0;
  bit finished = 0;
  logic [EW-1:0] q_exp[$];
  string q_tag[$];

  always #5 clk = ~clk;

  qrot_prerotate uut (.*);

  function automatic logic [XY_W-1:0] nsat(input logic [XY_W-1:0] a);
    if (a == 16'h8000) return 16'h7fff;
    return XY_W'(-$signed(a));
  endfunction

  function automatic logic [EW-1:0] model(input logic [XY_W-1:0] x, y,
      input logic [Z_W-1:0] z, input logic vec, input logic [1:0] cs);
    logic [XY_W-1:0] ox = x, oy = y;
    logic [Z_W-1:0] oz = z;
    logic signed [Z_W-1:0] q = Z_W'(QT);
    if (cs == 2'b01) begin
      if (!vec) begin
        if ($signed(z) > q) begin ox = nsat(y); oy = x; oz = z - q; end
        else if ($signed(z) < -q) begin ox = y; oy = nsat(x); oz = z + q; end
      end else if ($signed(x) < 0) begin
        if ($signed(y) >= 0) begin ox = y; oy = nsat(x); oz = z + q; end
        else begin ox = nsat(y); oy = x; oz = z - q; end
      end
    end
    return {ox, oy, oz, vec, cs};
  endfunction

  task automatic chk(input string tag, input logic [EW-1:0] got, input logic [EW-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic send(input string tag, input int x, input int y, input int z,
                      input logic vec, input logic [1:0] cs);
    @(negedge clk);
    in_x = XY_W'(x); in_y = XY_W'(y); in_z = Z_W'(z);
    in_vec = vec; in_coord = cs; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    q_exp.push_back(model(in_x, in_y, in_z, vec, cs));
    q_tag.push_back(tag);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // ready generator, changes away from both edges
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #2;
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom % 3) != 0;
        default: out_ready = 1'b0;
      endcase
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        if (q_exp.size() == 0) begin
          compared++; mismatched++;
          $display("FAIL R1: unexpected output %h expected none",
                   {out_x, out_y, out_z, out_vec, out_coord});
        end else begin
          chk(q_tag.pop_front(), {out_x, out_y, out_z, out_vec, out_coord}, q_exp.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    logic [EW-1:0] held;
    repeat (3) @(negedge clk);
    chk("R12 reset", {{(EW-2){1'b0}}, out_valid, in_ready}, {{(EW-2){1'b0}}, 2'b01});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send("R4 ccw", 1000, 200, 60000, 1'b0, 2'b01);
    send("R5 cw", 1000, -300, -70000, 1'b0, 2'b01);
    send("R6 upper bound", 123, 456, QT, 1'b0, 2'b01);
    send("R6 lower bound", 123, 456, -QT, 1'b0, 2'b01);
    send("R4 one above", 5, 6, QT + 1, 1'b0, 2'b01);
    send("R5 one below", 5, 6, -QT - 1, 1'b0, 2'b01);
    send("R7 q2", -500, 300, 0, 1'b1, 2'b01);
    send("R7 y zero", -500, 0, 0, 1'b1, 2'b01);
    send("R8 q3", -500, -300, 0, 1'b1, 2'b01);
    send("R9 x zero", 0, -5, 0, 1'b1, 2'b01);
    send("R9 q1", 700, 100, 0, 1'b1, 2'b01);
    send("R10 rot", 9, -32768, 60000, 1'b0, 2'b01);
    send("R10 vec", -32768, 0, 0, 1'b1, 2'b01);
    send("R3 linear", -100, 7, 100000, 1'b0, 2'b00);
    send("R3 hyperbolic", -100, -7, 0, 1'b1, 2'b10);
    send("R3 spare", -100, 7, -100000, 1'b0, 2'b11);
    send("R11 sideband", 1, 2, 3, 1'b1, 2'b10);

    // R2: park a sample under back-pressure
    wait (q_exp.size() == 0);
    rdy_mode = 2;
    @(posedge clk); #3;
    send("R2 parked", 2222, -1111, -90000, 1'b0, 2'b01);
    @(negedge clk);
    chk("R2 blocked", {{(EW-2){1'b0}}, out_valid, in_ready}, {{(EW-2){1'b0}}, 2'b10});
    held = {out_x, out_y, out_z, out_vec, out_coord};
    repeat (3) @(negedge clk);
    chk("R2 hold", {out_x, out_y, out_z, out_vec, out_coord}, held);
    chk("R1 valid held", {{(EW-1){1'b0}}, out_valid}, {{(EW-1){1'b0}}, 1'b1});
    rdy_mode = 0;

    // randomized stretch with irregular back-pressure
    rdy_mode = 1;
    for (int i = 0; i < 300; i++) begin
      send("R1 random", $urandom, $urandom, int'($urandom % 205888) - 102944,
           1'($urandom), 2'($urandom));
    end
    rdy_mode = 0;
    wait (q_exp.size() == 0);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule